// File: doc/BRIEF.md
# VGA Sync Sequencer

This block produces the raster timing for a 640-pixel-wide display. It counts pixel positions from a pixel-rate enable, which it derives from the system clock by a fixed integer divide. A horizontal counter runs through 800 positions per line. It drives an active-low horizontal sync pulse early in the line and a one-clock line-start strobe when the count wraps.

A vertical sequencer advances once per line, at the line-start strobe. It steps through four phases: visible, waiting for vertical sync, vertical sync, and waiting for frame end. It reports the current line number, a line-active flag and a one-clock frame-start pulse.

A static mode input selects one of two vertical timings:

- a 480-visible-line frame with an active-low vertical sync;
- a 400-visible-line frame with an active-high vertical sync.

The mode input is captured in reset and at each frame wrap, so a change in mid-frame waits for the next frame.

Top module: `vga_scan_sequencer`

## Requirements
- R1: The horizontal position advances by one every CLK_DIV clocks and runs 0 to H_TOTAL-1 (default 799) before returning to 0. line_start is high for exactly one clock: the clock whose enable moves the position from H_TOTAL-1 to 0.
- R2: hsync_n is low while the horizontal position is in [HS_START, HS_END) (defaults 16 and 48, a 32-position pulse) and high otherwise.
- R3: With mode 0 latched (480-line mode), a frame has 525 lines and lines 0 to 479 are visible. vsync is low on lines 490 and 491 and high on every other line.
- R4: With mode 1 latched (400-line mode), a frame has 445 lines and lines 0 to 399 are visible. vsync is high on lines 401, 402 and 403 and low on every other line.
- R5: line_num increments by one on each line_start. On the line_start that ends line total-1 of the latched mode, it returns to 0.
- R6: line_active is high only on visible lines of a frame that began with a wrap to line 0. The partial frame that follows reset has no active lines.
- R7: frame_start is high for exactly one clock: the first clock in which line_num reads 0 after a wrap. It is never high after reset before the first wrap.
- R8: mode_sel is sampled only while reset is high and at the clock edge of the wrapping line_start. A change at any other time has no effect on line totals, visible range or vsync polarity until the next wrap.
- R9: After reset, the outputs are:
  - hsync_n high;
  - line_num 0;
  - line_active, line_start and frame_start low;
  - vsync at the inactive level of mode_sel, which is high for mode 0 and low for mode 1.

  After reset the vertical phase is waiting-for-vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 selects the 480-line mode, 1 selects the 400-line mode |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, polarity set by the latched mode |
| line_active | output | 1 | Current line lies in the visible region |
| line_start | output | 1 | One-clock strobe at the horizontal wrap |
| frame_start | output | 1 | One-clock pulse when the line number returns to 0 |
| line_num | output | 10 | Current line number |

## Verification
Two events can land on the same clock edge: the frame wrap, which clears the line number and pulses frame_start, and a change of mode_sel. That edge is the one instant at which the mode is captured. The bench provokes this by flipping mode_sel in the clock just before the wrapping line_start, and it also flips mode_sel at random points inside frames. Its reference model latches the mode only at the wrap. The next frame's length, visible range and vsync polarity must therefore follow the value present at that edge, and every mid-frame flip must leave the current frame unchanged.

// File: rtl/vss_pkg.sv
package vss_pkg;

    localparam int LINE_W = 10;

    typedef enum logic [1:0] {
        PH_VISIBLE = 2'd0,
        PH_PRE     = 2'd1,
        PH_PULSE   = 2'd2,
        PH_POST    = 2'd3
    } vphase_t;

    typedef enum logic {
        MODE_480 = 1'b0,
        MODE_400 = 1'b1
    } vmode_t;

    typedef struct packed {
        logic [LINE_W-1:0] total;
        logic [LINE_W-1:0] visible;
        logic [LINE_W-1:0] vs_first;
        logic [LINE_W-1:0] vs_stop;
        logic              pol_high;
    } vtiming_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        vphase_t           phase;
        vmode_t            mode;
        logic              vs_on;
        logic              fs;
    } vstate_t;

    function automatic vtiming_t timing_of(input vmode_t m);
        vtiming_t t;
        if (m == MODE_400) begin
            t.total    = LINE_W'(445);
            t.visible  = LINE_W'(400);
            t.vs_first = LINE_W'(401);
            t.vs_stop  = LINE_W'(404);
            t.pol_high = 1'b1;
        end else begin
            t.total    = LINE_W'(525);
            t.visible  = LINE_W'(480);
            t.vs_first = LINE_W'(490);
            t.vs_stop  = LINE_W'(492);
            t.pol_high = 1'b0;
        end
        return t;
    endfunction

    function automatic logic sync_level(input logic on, input logic pol_high);
        return pol_high ? on : ~on;
    endfunction

endpackage

// File: rtl/vss_pix_tick.sv
module vss_pix_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    generate
        if (CLK_DIV > 1) begin : g_div
            localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst)               cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == LAST);

            // R1
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/vss_hline.sv
module vss_hline #(
    parameter int H_TOTAL  = 800,
    parameter int HS_START = 16,
    parameter int HS_END   = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic line_start,
    output logic hsync_n
);
    localparam int HW = $clog2(H_TOTAL);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] HS_LO  = HW'(HS_START);
    localparam logic [HW-1:0] HS_HI  = HW'(HS_END);

    logic [HW-1:0] hcnt_q;
    logic          at_last;

    assign at_last = (hcnt_q == H_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            hcnt_q <= '0;
        else if (tick)
            hcnt_q <= at_last ? '0 : hcnt_q + 1'b1;
    end

    assign line_start = tick && at_last;
    assign hsync_n    = !((hcnt_q >= HS_LO) && (hcnt_q < HS_HI));

    // R1
    hcount_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(hcnt_q) < H_TOTAL);

    // R1
    hcount_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> hcnt_q == '0);

    // R2
    hsync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> int'(hcnt_q) == HS_START);
endmodule

// File: rtl/vss_vseq.sv
module vss_vseq
    import vss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              mode_sel,
    output logic              vsync,
    output logic              line_active,
    output logic              frame_start,
    output logic [LINE_W-1:0] line_num
);
    vstate_t  cur_q;
    vstate_t  nxt;
    vtiming_t tm;
    logic [LINE_W-1:0] line_inc;

    assign tm       = timing_of(cur_q.mode);
    assign line_inc = cur_q.line + 1'b1;

    always_comb begin
        nxt    = cur_q;
        nxt.fs = 1'b0;
        if (line_start) begin
            if (cur_q.line == tm.total - 1'b1) begin
                nxt.line  = '0;
                nxt.phase = PH_VISIBLE;
                nxt.mode  = vmode_t'(mode_sel);
                nxt.vs_on = 1'b0;
                nxt.fs    = 1'b1;
            end else begin
                nxt.line = line_inc;
                unique case (cur_q.phase)
                    PH_VISIBLE: if (line_inc == tm.visible) nxt.phase = PH_PRE;
                    PH_PRE: if (line_inc == tm.vs_first) begin
                        nxt.phase = PH_PULSE;
                        nxt.vs_on = 1'b1;
                    end
                    PH_PULSE: if (line_inc == tm.vs_stop) begin
                        nxt.phase = PH_POST;
                        nxt.vs_on = 1'b0;
                    end
                    PH_POST: nxt.phase = PH_POST;
                    default: nxt.phase = PH_PRE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.line  <= '0;
            cur_q.phase <= PH_PRE;
            cur_q.mode  <= vmode_t'(mode_sel);
            cur_q.vs_on <= 1'b0;
            cur_q.fs    <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign vsync       = sync_level(cur_q.vs_on, tm.pol_high);
    assign line_active = (cur_q.phase == PH_VISIBLE);
    assign frame_start = cur_q.fs;
    assign line_num    = cur_q.line;

    // R5
    line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_num == '0);

    // R7
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R6
    active_range_chk: assert property (@(posedge clk) disable iff (rst)
        line_active |-> line_num < tm.visible);

    // R3
    vs_window_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.vs_on |-> (line_num >= tm.vs_first) && (line_num < tm.vs_stop));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (line_num != '0) |-> $stable(cur_q.mode));

    // R5
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_start && !$past(line_start)) |-> $stable(line_num));
endmodule

// File: rtl/vga_scan_sequencer.sv
module vga_scan_sequencer
    import vss_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int H_TOTAL  = 800,
    parameter int HS_START = 16,
    parameter int HS_END   = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    output logic              hsync_n,
    output logic              vsync,
    output logic              line_active,
    output logic              line_start,
    output logic              frame_start,
    output logic [LINE_W-1:0] line_num
);
    logic tick;

    vss_pix_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    vss_hline #(
        .H_TOTAL  (H_TOTAL),
        .HS_START (HS_START),
        .HS_END   (HS_END)
    ) u_hline (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .line_start (line_start),
        .hsync_n    (hsync_n)
    );

    vss_vseq u_vseq (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .mode_sel    (mode_sel),
        .vsync       (vsync),
        .line_active (line_active),
        .frame_start (frame_start),
        .line_num    (line_num)
    );

    // R1
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);
endmodule

// File: tb/tb_vga_scan_sequencer.sv
`timescale 1ns/1ps
module tb_vga_scan_sequencer;
    localparam int DIV  = 2;
    localparam int HT   = 64;
    localparam int HSS  = 16;
    localparam int HSE  = 48;
    localparam int RUN  = 135000;
    localparam int WDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic hsync_n, vsync, line_active, line_start, frame_start;
    logic [9:0] line_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vga_scan_sequencer #(.CLK_DIV(DIV), .H_TOTAL(HT), .HS_START(HSS), .HS_END(HSE)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .hsync_n(hsync_n), .vsync(vsync),
        .line_active(line_active), .line_start(line_start), .frame_start(frame_start),
        .line_num(line_num)
    );

    // reference model state
    int m_div, m_h, m_line, m_mode;
    bit m_started, m_fs;

    function automatic int f_total(input int md);   return md ? 445 : 525; endfunction
    function automatic int f_vis(input int md);     return md ? 400 : 480; endfunction
    function automatic int f_vs_first(input int md); return md ? 401 : 490; endfunction
    function automatic int f_vs_stop(input int md);  return md ? 404 : 492; endfunction
    function automatic int f_vsync(input int md, input int ln);
        bit on;
        on = (ln >= f_vs_first(md)) && (ln < f_vs_stop(md));
        return md ? int'(on) : int'(!on);
    endfunction
    function automatic int f_hsync(input int h);
        return ((h >= HSS) && (h < HSE)) ? 0 : 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit tk, ls;
        tk = (m_div == DIV - 1);
        m_div = (m_div + 1) % DIV;
        ls = tk && (m_h == HT - 1);
        if (tk) m_h = (m_h + 1) % HT;
        m_fs = 1'b0;
        if (ls) begin
            if (m_line == f_total(m_mode) - 1) begin
                m_line = 0;
                m_mode = int'(mode_sel);
                m_started = 1'b1;
                m_fs = 1'b1;
            end else begin
                m_line++;
            end
        end
    endtask

    task automatic compare_all();
        chk("R2", "hsync_n", int'(hsync_n), f_hsync(m_h));
        chk("R1", "line_start", int'(line_start), int'((m_div == DIV - 1) && (m_h == HT - 1)));
        chk("R5", "line_num", int'(line_num), m_line);
        if (m_mode == 0) chk("R3", "vsync", int'(vsync), f_vsync(0, m_line));
        else             chk("R4", "vsync", int'(vsync), f_vsync(1, m_line));
        chk("R6", "line_active", int'(line_active), int'(m_started && (m_line < f_vis(m_mode))));
        chk("R7", "frame_start", int'(frame_start), int'(m_fs));
        if (int'(mode_sel) != m_mode)
            chk("R8", "vsync under pending mode", int'(vsync), f_vsync(m_mode, m_line));
    endtask

    initial begin
        void'($urandom(32'd1207));
        rst = 1'b1;
        mode_sel = 1'b0;
        repeat (4) @(negedge clk);
        // R9 reset state, mode 0
        chk("R9", "hsync_n", int'(hsync_n), 1);
        chk("R9", "vsync m0", int'(vsync), 1);
        chk("R9", "line_num", int'(line_num), 0);
        chk("R9", "line_active", int'(line_active), 0);
        chk("R9", "line_start", int'(line_start), 0);
        chk("R9", "frame_start", int'(frame_start), 0);
        mode_sel = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", "vsync m1", int'(vsync), 0);
        chk("R8", "mode sampled in reset", int'(vsync), 0);
        mode_sel = 1'b0;
        @(negedge clk);
        chk("R9", "vsync back to m0", int'(vsync), 1);

        m_div = 0; m_h = 0; m_line = 0; m_mode = 0; m_started = 1'b0; m_fs = 1'b0;
        rst = 1'b0;
        for (int n = 0; n < RUN; n++) begin
            @(negedge clk);
            model_step();
            compare_all();
            if ((m_div == DIV - 1) && (m_h == HT - 1) && (m_line == f_total(m_mode) - 1)) begin
                // directed corner: change mode on the very edge of the frame wrap
                if (!m_started) mode_sel = 1'b1;
                else            mode_sel = ($urandom % 2) != 0;
            end else if (($urandom % 3000) == 0) begin
                mode_sel = ~mode_sel;
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(WDOG * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule